// File: doc/BRIEF.md
# Serial Byte Receiver with Cascadable Parity

This block takes asynchronous serial frames from one data line and turns each into an 8-bit byte. The line rests high. A frame opens with a low start bit, carries eight data bits with the least significant bit first, and closes with a high stop bit. The line passes through a two-flop synchronizer. A falling edge seen while the block is idle starts reception.

Two timers then run together. A bit timer, made by dividing the system clock down to one bit time, acts as the shift clock and samples each data bit near its middle. A frame timer of ten bit times sets the length of the reception. When it expires, shifting stops, the byte stays in its register, the busy flag drops and the block waits for the next falling edge.

A parity stage reads the held byte. It XORs the eight bits with a cascade input, so several blocks can be chained to cover wider words. It gives an even flag (the XNOR form) and an odd flag (the XOR form). Both flags are forced low when the enable input is low.

Top module: `serial_parity_rx`

## Requirements
- R1: While reset is asserted and just after it is released, `rx_busy` is 0 and `rx_byte` is 8'h00.
- R2: A high-to-low transition of `rx_line` while `rx_busy` is 0 raises `rx_busy` within four clock cycles. `rx_busy` is still 0 one cycle after the transition.
- R3: The bit period is CLK_HZ/BAUD clock cycles. The eight data bits that follow the start bit are sampled near mid-bit and land in `rx_byte`, the first-received bit in bit 0.
- R4: `rx_busy` stays high for exactly ten bit periods from the cycle it rose. It then clears, and the block accepts a new start edge.
- R5: Falling edges on `rx_line` while `rx_busy` is high do not restart reception. Busy remains high and still ends on the original schedule.
- R6: While `rx_busy` is low, `rx_byte` holds the last received byte whatever `rx_line` does while it stays high.
- R7: With `par_en` = 1, `par_odd` equals the XOR of the eight bits of `rx_byte` and `casc_in`, and `par_even` is its complement.
- R8: With `par_en` = 0, `par_even` and `par_odd` are both 0.
- R9: The parity flags follow `par_en`, `casc_in` and `rx_byte` with no clock delay. Toggling `casc_in` swaps the two flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous serial data line, idle high |
| par_en | input | 1 | Parity enable; both flags low when 0 |
| casc_in | input | 1 | Cascade parity input from a preceding stage |
| rx_byte | output | 8 | Received byte, held between frames |
| rx_busy | output | 1 | High while a frame is being received |
| par_even | output | 1 | Even-parity flag |
| par_odd | output | 1 | Odd-parity flag |

## Verification
The embedded assertions check the following on every cycle:
- the frame counter only advances while busy and never overruns ten bit periods;
- busy rises only after the synchronized line went low and falls only at the frame limit;
- the byte does not move while idle;
- the two parity flags are mutually exclusive when enabled and both low when disabled.

Only the bench's scenarios can show that bits land in the right positions at mid-bit sampling, that the busy window has the right absolute length, and that the parity values are correct for specific bytes and cascade inputs.

// File: rtl/sp_pkg.sv
package sp_pkg;
    // Bit periods in one frame: start + data + stop
    localparam int FRAME_BITS = 10;
    // Payload width
    localparam int DATA_BITS  = 8;
    // Bit-timer ticks per frame (start mid, data mids, stop mid)
    localparam int TICK_LAST  = DATA_BITS + 1;
endpackage

// File: rtl/sp_sync2.sv
module sp_sync2 #(
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = async_in;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk) begin
        if (rst) sy_q <= '{s1: RESET_VAL, s2: RESET_VAL};
        else     sy_q <= sy_d;
    end

    assign sync_out = sy_q.s2;
endmodule

// File: rtl/sp_frame_rx.sv
module sp_frame_rx
    import sp_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int BAUD   = 9600
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 line_s,
    output logic [DATA_BITS-1:0] byte_o,
    output logic                 busy_o
);
    localparam int BIT_CYC   = CLK_HZ / BAUD;
    localparam int HALF_CYC  = BIT_CYC / 2;
    localparam int CW        = $clog2(BIT_CYC);
    localparam int FRAME_CYC = FRAME_BITS * BIT_CYC;
    localparam int FW        = $clog2(FRAME_CYC);
    localparam int TW        = $clog2(TICK_LAST + 1);

    localparam logic [CW-1:0] BIT_LAST   = CW'(BIT_CYC - 1);
    localparam logic [CW-1:0] BIT_START  = CW'(HALF_CYC);
    localparam logic [FW-1:0] FRAME_LAST = FW'(FRAME_CYC - 1);
    localparam logic [TW-1:0] TICK_MAX   = TW'(TICK_LAST);
    localparam logic [TW-1:0] TICK_DATA0 = TW'(1);
    localparam logic [TW-1:0] TICK_DATAN = TW'(DATA_BITS);

    typedef struct packed {
        logic                 active;
        logic [CW-1:0]        bit_cnt;
        logic [TW-1:0]        tick;
        logic [FW-1:0]        frame_cnt;
        logic [DATA_BITS-1:0] shreg;
        logic                 prev;
    } rx_t;

    rx_t rx_d, rx_q;

    logic fall_det;
    logic bit_tick;
    logic frame_end;
    logic shift_en;

    always_comb begin
        fall_det  = rx_q.prev & ~line_s;
        bit_tick  = rx_q.active && (rx_q.bit_cnt == BIT_LAST);
        frame_end = rx_q.active && (rx_q.frame_cnt == FRAME_LAST);
        // frame timer gates the shift clock; only data-bit ticks shift
        shift_en  = bit_tick && !frame_end &&
                    (rx_q.tick >= TICK_DATA0) && (rx_q.tick <= TICK_DATAN);

        rx_d      = rx_q;
        rx_d.prev = line_s;

        if (!rx_q.active) begin
            if (fall_det) begin
                rx_d.active    = 1'b1;
                rx_d.bit_cnt   = BIT_START;
                rx_d.tick      = '0;
                rx_d.frame_cnt = '0;
            end
        end else begin
            rx_d.bit_cnt = bit_tick ? '0 : rx_q.bit_cnt + CW'(1);
            if (bit_tick && (rx_q.tick != TICK_MAX))
                rx_d.tick = rx_q.tick + TW'(1);
            if (shift_en)
                rx_d.shreg = {line_s, rx_q.shreg[DATA_BITS-1:1]};
            if (frame_end)
                rx_d.active = 1'b0;
            else
                rx_d.frame_cnt = rx_q.frame_cnt + FW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q.active    <= 1'b0;
            rx_q.bit_cnt   <= '0;
            rx_q.tick      <= '0;
            rx_q.frame_cnt <= '0;
            rx_q.shreg     <= '0;
            rx_q.prev      <= 1'b1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign byte_o = rx_q.shreg;
    assign busy_o = rx_q.active;

    // R2: reception starts only after the synchronized line was seen low
    a_r2_start_on_low: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_q.active) |-> !$past(line_s));

    // R4: frame counter never passes the ten-bit limit
    a_r4_frame_bound: assert property (@(posedge clk) disable iff (rst)
        rx_q.active |-> (rx_q.frame_cnt <= FRAME_LAST));

    // R4: busy drops only when the frame limit was reached
    a_r4_end_at_limit: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_q.active) |-> ($past(rx_q.frame_cnt) == FRAME_LAST));

    // R5: while busy, the frame counter only steps forward (no restart)
    a_r5_no_restart: assert property (@(posedge clk) disable iff (rst)
        rx_q.active |=> (!rx_q.active ||
                         rx_q.frame_cnt == $past(rx_q.frame_cnt) + FW'(1)));

    // R6: the byte is frozen while idle
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !rx_q.active |=> $stable(rx_q.shreg));

    // R3: tick index stays in its range
    a_r3_tick_range: assert property (@(posedge clk) disable iff (rst)
        rx_q.tick <= TICK_MAX);
endmodule

// File: rtl/sp_parity.sv
module sp_parity
    import sp_pkg::*;
(
    input  logic                 rst,
    input  logic [DATA_BITS-1:0] data_i,
    input  logic                 casc_i,
    input  logic                 en_i,
    output logic                 even_o,
    output logic                 odd_o
);
    logic [DATA_BITS:0] chain;

    assign chain[0] = casc_i;

    genvar gi;
    generate
        for (gi = 0; gi < DATA_BITS; gi++) begin : g_xor
            assign chain[gi+1] = chain[gi] ^ data_i[gi];
        end
    endgenerate

    assign odd_o  = en_i &  chain[DATA_BITS];
    assign even_o = en_i & ~chain[DATA_BITS];

    always_comb begin
        if (!rst) begin
            // R8: disabled means both flags low
            a_r8_disabled_low: assert (en_i || (!even_o && !odd_o));
            // R7: when enabled exactly one flag is set
            a_r7_one_hot: assert (!en_i || (even_o ^ odd_o));
        end
    end
endmodule

// File: rtl/serial_parity_rx.sv
module serial_parity_rx #(
    parameter int CLK_HZ = 50_000_000,
    parameter int BAUD   = 9600
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_line,
    input  logic       par_en,
    input  logic       casc_in,
    output logic [7:0] rx_byte,
    output logic       rx_busy,
    output logic       par_even,
    output logic       par_odd
);
    logic line_s;

    sp_sync2 #(.RESET_VAL(1'b1)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (rx_line),
        .sync_out (line_s)
    );

    sp_frame_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .line_s (line_s),
        .byte_o (rx_byte),
        .busy_o (rx_busy)
    );

    sp_parity u_par (
        .rst    (rst),
        .data_i (rx_byte),
        .casc_i (casc_in),
        .en_i   (par_en),
        .even_o (par_even),
        .odd_o  (par_odd)
    );
endmodule

// File: tb/tb_serial_parity_rx.sv
module tb_serial_parity_rx;
    localparam int CLK_PERIOD = 10;
    localparam int T_CLK_HZ   = 160000;
    localparam int T_BAUD     = 10000;
    localparam int BIT        = T_CLK_HZ / T_BAUD;
    localparam int NVEC       = 8;

    // {byte, casc, en, exp_even, exp_odd}
    localparam logic [11:0] VEC [NVEC] = '{
        {8'hA5, 1'b0, 1'b1, 1'b1, 1'b0},
        {8'h01, 1'b0, 1'b1, 1'b0, 1'b1},
        {8'hFF, 1'b1, 1'b1, 1'b0, 1'b1},
        {8'h80, 1'b1, 1'b1, 1'b1, 1'b0},
        {8'h3C, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'h00, 1'b0, 1'b1, 1'b1, 1'b0},
        {8'h7E, 1'b1, 1'b1, 1'b0, 1'b1},
        {8'h96, 1'b1, 1'b0, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic       par_en = 1'b0;
    logic       casc_in = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_busy;
    logic       par_even;
    logic       par_odd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_parity_rx #(.CLK_HZ(T_CLK_HZ), .BAUD(T_BAUD)) dut (
        .clk(clk), .rst(rst), .rx_line(rx_line), .par_en(par_en),
        .casc_in(casc_in), .rx_byte(rx_byte), .rx_busy(rx_busy),
        .par_even(par_even), .par_odd(par_odd)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    // Sends one frame; checks start detection and busy window (R2, R4, R5)
    task automatic send_frame(input logic [7:0] b);
        @(negedge clk);
        rx_line = 1'b0;
        step(1);
        chk("R2 busy not yet", {7'b0, rx_busy}, 8'd0);
        step(3);
        chk("R2 busy raised", {7'b0, rx_busy}, 8'd1);
        step(BIT - 4);
        for (int k = 0; k < 8; k++) begin
            rx_line = b[k];
            step(BIT);
        end
        rx_line = 1'b1;
        step(BIT / 2);
        chk("R5 busy through frame", {7'b0, rx_busy}, 8'd1);
        step(BIT - BIT / 2 + 1);
        chk("R4 busy at ten bits", {7'b0, rx_busy}, 8'd1);
        step(3);
        chk("R4 busy cleared", {7'b0, rx_busy}, 8'd0);
    endtask

    initial begin
        step(5);
        chk("R1 busy reset", {7'b0, rx_busy}, 8'd0);
        chk("R1 byte reset", rx_byte, 8'h00);
        rst = 1'b0;
        step(2);
        chk("R1 byte after release", rx_byte, 8'h00);
        chk("R8 flags off", {6'b0, par_even, par_odd}, 8'd0);

        // Table walk: R3 R7 R8
        for (int v = 0; v < NVEC; v++) begin
            casc_in = VEC[v][3];
            par_en  = VEC[v][2];
            send_frame(VEC[v][11:4]);
            step(BIT);
            chk("R3 byte", rx_byte, VEC[v][11:4]);
            chk("R7 even flag", {7'b0, par_even}, {7'b0, VEC[v][1]});
            chk("R7 odd flag", {7'b0, par_odd}, {7'b0, VEC[v][0]});
        end

        // R5: alternating bits put many falling edges inside the frame
        par_en = 1'b1; casc_in = 1'b0;
        send_frame(8'h55);
        step(2);
        chk("R5 byte with inner edges", rx_byte, 8'h55);

        // R6: hold across a long idle stretch
        step(6 * BIT);
        chk("R6 byte held", rx_byte, 8'h55);

        // R9: immediate response to cascade and enable
        chk("R9 even before flip", {7'b0, par_even}, 8'd1);
        casc_in = 1'b1; #1;
        chk("R9 odd after flip", {7'b0, par_odd}, 8'd1);
        chk("R9 even after flip", {7'b0, par_even}, 8'd0);
        par_en = 1'b0; #1;
        chk("R8 disabled", {6'b0, par_even, par_odd}, 8'd0);
        par_en = 1'b1; #1;
        chk("R9 reenabled", {6'b0, par_even, par_odd}, 8'd1);

        // R4: rearm immediately after busy cleared
        send_frame(8'hC3);
        step(2);
        chk("R4 rearmed frame", rx_byte, 8'hC3);

        // R1: reset mid-frame returns to idle
        @(negedge clk);
        rx_line = 1'b0;
        step(3 * BIT);
        rst = 1'b1;
        rx_line = 1'b1;
        step(2);
        chk("R1 busy reset mid-frame", {7'b0, rx_busy}, 8'd0);
        chk("R1 byte reset mid-frame", rx_byte, 8'h00);
        rst = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule